// File: doc/BRIEF.md
# Window Watchdog Period Checker

This block supervises a heartbeat pulse train sent by a processor and judges whether the time between successive falling edges stays inside a window. The heartbeat is first brought into the local clock domain. Only its high-to-low transitions are then used for timing. A counter measures each interval in units of a shared time base. Each count step is gated by a tick enable that the surrounding logic supplies.

An interval that reaches the maximum count marks the train as too slow. This also covers a heartbeat stuck at either level, because no falling edge arrives and the counter keeps counting. In full-window mode, an interval shorter than the minimum count marks the train as too fast. In lower-limit-only mode, the minimum check is switched off. Fault flags stay set until one interval lands inside the window. A downstream controller reads the in-window status and the two fault flags to decide on resets or power actions.

Top module: `wdw_period_check`

## Requirements
- R1: `wd_in` passes through two synchronizer flops. A falling edge driven before clock edge k is acted on at edge k+2: the flags and the counter change after that edge, and not after edge k+1.
- R2: Rising edges of `wd_in` neither restart the interval counter nor produce a verdict.
- R3: The interval counter advances only on cycles with `tick_en` high. It restarts from zero on the clock where a falling edge is taken. The value judged at a falling edge is the number of ticks counted since the previous restart.
- R4: The counter saturates at MAX_TICKS (default 130). On the clock after saturation with no falling edge, `too_slow` goes high. A heartbeat held high or held low therefore ends in `too_slow`.
- R5: The first falling edge after reset only starts timing. It yields no verdict, so reset leaves `too_fast` low and `too_slow` high.
- R6: In full-window mode (`LOWER_ONLY`=0), a judged interval below MIN_TICKS (default 38) sets `too_fast`.
- R7: A judged interval from MIN_TICKS to MAX_TICKS-1 inclusive clears both fault flags, which raises `in_window`. A judged interval equal to MAX_TICKS sets `too_slow`.
- R8: With `LOWER_ONLY`=1, `too_fast` never rises, and any judged interval below MAX_TICKS counts as in-window.
- R9: Synchronous active-high `rst` gives `too_slow`=1, `too_fast`=0 and `in_window`=0 after the clock edge.
- R10: Fault flags are sticky. A too-fast fault followed by a too-slow fault leaves both flags set until an in-window interval arrives.
- R11: `in_window` is high exactly when both fault flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wd_in | input | 1 | Asynchronous heartbeat from the processor |
| tick_en | input | 1 | Time-base enable; one counter step per high cycle |
| in_window | output | 1 | Heartbeat judged inside the window |
| too_slow | output | 1 | Sticky fault: interval reached the maximum or the heartbeat is stuck |
| too_fast | output | 1 | Sticky fault: interval below the minimum (full-window mode only) |

## Verification
The heartbeat is driven as trains with periods just inside and just outside both limits, in cycles, with the tick enable held high. These trains separate an off-by-one comparator at either window edge. Each train is also applied to a lower-limit-only instance, which must not report fast periods.

A train that is judged differently when the tick enable is high on only one cycle in three shows that the counter respects the time base. A long low phase followed by a short high phase distinguishes timing on falling edges from timing on rising edges. Stuck-high and stuck-low levels, a short first interval after reset, and a fast-then-slow sequence exercise saturation, arming and flag stickiness. A single late edge measures the synchronizer latency.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    localparam int unsigned WDW_MAX_DEF  = 130;
    localparam int unsigned WDW_MIN_DEF  = 38;
    localparam int unsigned WDW_SYNC_DEF = 2;

    typedef enum logic [1:0] {
        IV_GOOD = 2'd0,
        IV_FAST = 2'd1,
        IV_SLOW = 2'd2
    } iv_class_t;

    typedef struct packed {
        logic slow;
        logic fast;
    } wdw_fault_t;

    localparam wdw_fault_t WDW_FAULT_RESET = '{slow: 1'b1, fast: 1'b0};
    localparam wdw_fault_t WDW_FAULT_CLEAR = '{slow: 1'b0, fast: 1'b0};

    // Saturation dominates; a short interval is only fast if not saturated.
    function automatic iv_class_t wdw_classify(input logic at_max, input logic short_iv);
        if (at_max)
            return IV_SLOW;
        else if (short_iv)
            return IV_FAST;
        else
            return IV_GOOD;
    endfunction

endpackage

// File: rtl/wdw_sync_fall.sv
module wdw_sync_fall #(
    parameter int unsigned STAGES = wdw_pkg::WDW_SYNC_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[STAGES-1];
    end

    // High-to-low only; rising transitions produce nothing (R2)
    assign fall = last_q & ~chain[STAGES-1];
endmodule

// File: rtl/wdw_interval_cnt.sv
module wdw_interval_cnt #(
    parameter int unsigned MAX_TICKS = wdw_pkg::WDW_MAX_DEF,
    localparam int unsigned CNT_W    = $clog2(MAX_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count,
    output logic             at_max
);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_TICKS);

    assign at_max = (count == MAX_C);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (restart)
            count <= '0;
        else if (tick_en && !at_max)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/wdw_verdict.sv
module wdw_verdict
    import wdw_pkg::*;
#(
    parameter int unsigned MIN_TICKS  = WDW_MIN_DEF,
    parameter int unsigned MAX_TICKS  = WDW_MAX_DEF,
    parameter bit          LOWER_ONLY = 1'b0,
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fall,
    input  logic [CNT_W-1:0] count,
    input  logic             at_max,
    output wdw_fault_t       faults
);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_TICKS);

    logic      armed;
    logic      short_iv;
    iv_class_t cls;

    generate
        if (LOWER_ONLY) begin : g_lower
            assign short_iv = 1'b0;
        end else begin : g_full
            assign short_iv = (count < MIN_C);
        end
    endgenerate

    assign cls = wdw_classify(at_max, short_iv);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            faults <= WDW_FAULT_RESET;
        end else if (fall) begin
            armed <= 1'b1;
            if (armed) begin
                unique case (cls)
                    IV_SLOW: faults.slow <= 1'b1;
                    IV_FAST: faults.fast <= 1'b1;
                    default: faults      <= WDW_FAULT_CLEAR;
                endcase
            end
        end else if (at_max) begin
            faults.slow <= 1'b1;
        end
    end
endmodule

// File: rtl/wdw_period_check.sv
module wdw_period_check
    import wdw_pkg::*;
#(
    parameter int unsigned MIN_TICKS   = WDW_MIN_DEF,
    parameter int unsigned MAX_TICKS   = WDW_MAX_DEF,
    parameter int unsigned SYNC_STAGES = WDW_SYNC_DEF,
    parameter bit          LOWER_ONLY  = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic wd_in,
    input  logic tick_en,
    output logic in_window,
    output logic too_slow,
    output logic too_fast
);
    localparam int unsigned CNT_W = $clog2(MAX_TICKS + 1);

    logic             wd_fall;
    logic [CNT_W-1:0] elapsed;
    logic             at_max;
    wdw_fault_t       faults;

    wdw_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (wd_in),
        .fall     (wd_fall)
    );

    wdw_interval_cnt #(.MAX_TICKS(MAX_TICKS)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .restart (wd_fall),
        .tick_en (tick_en),
        .count   (elapsed),
        .at_max  (at_max)
    );

    wdw_verdict #(
        .MIN_TICKS  (MIN_TICKS),
        .MAX_TICKS  (MAX_TICKS),
        .LOWER_ONLY (LOWER_ONLY)
    ) u_verdict (
        .clk    (clk),
        .rst    (rst),
        .fall   (wd_fall),
        .count  (elapsed),
        .at_max (at_max),
        .faults (faults)
    );

    assign too_slow  = faults.slow;
    assign too_fast  = faults.fast;
    assign in_window = ~(faults.slow | faults.fast);
endmodule

// File: rtl/wdw_period_check_chk.sv
module wdw_period_check_chk #(
    parameter int unsigned MAX_TICKS  = 130,
    parameter bit          LOWER_ONLY = 1'b0,
    parameter int unsigned CNT_W      = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             wd_fall,
    input logic [CNT_W-1:0] elapsed,
    input logic             too_slow,
    input logic             too_fast
);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_TICKS);

    // R4: counter never passes the saturation value
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (rst)
        elapsed <= MAX_C);

    // R4: a saturated count with no edge forces the slow fault next cycle
    a_r4_slow_at_max: assert property (@(posedge clk) disable iff (rst)
        (elapsed == MAX_C && !wd_fall) |=> too_slow);

    // R3: no tick and no edge keeps the count
    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !wd_fall) |=> $stable(elapsed));

    // R3: a taken falling edge restarts the count
    a_r3_fall_restarts: assert property (@(posedge clk) disable iff (rst)
        wd_fall |=> (elapsed == '0));

    // R2: the fast flag only moves on a falling edge
    a_r2_fast_only_on_fall: assert property (@(posedge clk) disable iff (rst)
        !wd_fall |=> $stable(too_fast));

    // R8: lower-limit-only mode never reports fast
    a_r8_no_fast_lower: assert property (@(posedge clk) disable iff (rst)
        LOWER_ONLY |-> !too_fast);

    // R9: reset state
    a_r9_reset_state: assert property (@(posedge clk)
        rst |=> (too_slow && !too_fast && elapsed == '0));
endmodule

bind wdw_period_check wdw_period_check_chk #(
    .MAX_TICKS  (MAX_TICKS),
    .LOWER_ONLY (LOWER_ONLY),
    .CNT_W      (CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .wd_fall  (wd_fall),
    .elapsed  (elapsed),
    .too_slow (too_slow),
    .too_fast (too_fast)
);

// File: tb/test_wdw_period_check.sv
`timescale 1ns/1ps
module test_wdw_period_check;
    localparam int MINT = 38;
    localparam int MAXT = 130;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wd_in = 1'b1;
    logic tick_en = 1'b1;
    int   tick_div = 1;
    int   tick_phase = 0;

    logic f_win, f_slow, f_fast;
    logic l_win, l_slow, l_fast;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wdw_period_check i_wdw_period_check (
        .clk(clk), .rst(rst), .wd_in(wd_in), .tick_en(tick_en),
        .in_window(f_win), .too_slow(f_slow), .too_fast(f_fast)
    );

    wdw_period_check #(.LOWER_ONLY(1'b1)) i_wdw_period_check_lower (
        .clk(clk), .rst(rst), .wd_in(wd_in), .tick_en(tick_en),
        .in_window(l_win), .too_slow(l_slow), .too_fast(l_fast)
    );

    // Behavioural reference: index 0 full window, index 1 lower limit only
    int sh[3];
    int cnt[2];
    int armed[2];
    int mslow[2];
    int mfast[2];

    always @(posedge clk) begin
        int was_fall;
        was_fall = (sh[2] == 1 && sh[1] == 0);
        for (int m = 0; m < 2; m++) begin
            if (rst) begin
                cnt[m] = 0; armed[m] = 0; mslow[m] = 1; mfast[m] = 0;
            end else if (was_fall) begin
                if (armed[m] != 0) begin
                    if (cnt[m] >= MAXT) mslow[m] = 1;
                    else if (m == 0 && cnt[m] < MINT) mfast[m] = 1;
                    else begin mslow[m] = 0; mfast[m] = 0; end
                end
                armed[m] = 1;
                cnt[m] = 0;
            end else begin
                if (cnt[m] == MAXT) mslow[m] = 1;
                if (tick_en && cnt[m] < MAXT) cnt[m] = cnt[m] + 1;
            end
        end
        if (rst) begin
            sh[0] = 0; sh[1] = 0; sh[2] = 0;
        end else begin
            sh[2] = sh[1]; sh[1] = sh[0]; sh[0] = int'(wd_in);
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R4", "full too_slow", int'(f_slow), mslow[0]);
            chk("R6", "full too_fast", int'(f_fast), mfast[0]);
            chk("R11", "full in_window", int'(f_win), int'(mslow[0] == 0 && mfast[0] == 0));
            chk("R8", "lower too_fast", int'(l_fast), 0);
            chk("R7", "lower too_slow", int'(l_slow), mslow[1]);
            chk("R11", "lower in_window", int'(l_win), int'(mslow[1] == 0));
        end
    end

    // Time base: tick_en high on one cycle in tick_div
    always @(negedge clk) begin
        tick_phase = (tick_phase + 1 >= tick_div) ? 0 : tick_phase + 1;
        tick_en <= (tick_phase == 0);
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic train(input int period, input int n);
        for (int i = 0; i < n; i++) begin
            wd_in = 1'b0; cycles(period / 2);
            wd_in = 1'b1; cycles(period - period / 2);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; cycles(4); rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R9: reset state
        chk("R9", "reset too_slow", int'(f_slow), 1);
        chk("R9", "reset too_fast", int'(f_fast), 0);
        chk("R9", "reset in_window", int'(f_win), 0);

        // R5: early first edge only arms
        cycles(5); wd_in = 1'b0; cycles(5); wd_in = 1'b1; cycles(20);
        chk("R5", "first edge no fast", int'(f_fast), 0);
        chk("R5", "first edge still slow", int'(f_slow), 1);
        cycles(35);            // next fall 60 cycles after first
        train(60, 3);
        chk("R7", "60-cycle train in window", int'(f_win), 1);

        // R1: latency of a late (fast) edge
        wd_in = 1'b0; cycles(5); wd_in = 1'b1; cycles(5);
        chk("R1", "good before fast edge", int'(f_win), 1);
        wd_in = 1'b0;
        cycles(2);
        chk("R1", "no change after k+1", int'(f_fast), 0);
        cycles(1);
        chk("R1", "fast after k+2", int'(f_fast), 1);
        cycles(5); wd_in = 1'b1; cycles(50);

        // R6/R8: 38-cycle period, count 37 at each edge
        train(60, 2);
        train(38, 3);
        chk("R6", "38-cycle too_fast full", int'(f_fast), 1);
        chk("R8", "38-cycle lower in window", int'(l_win), 1);

        // R10: fast then slow keeps both
        wd_in = 1'b0; cycles(150); wd_in = 1'b1; cycles(5);
        chk("R10", "both flags set slow", int'(f_slow), 1);
        chk("R10", "both flags set fast", int'(f_fast), 1);

        // R7 boundary: 39 cycles -> count 38 good
        cycles(34); train(39, 3);
        chk("R7", "39-cycle in window", int'(f_win), 1);

        // R7 upper boundary: 130 good, 131 slow
        train(130, 3);
        chk("R7", "130-cycle in window", int'(f_win), 1);
        train(131, 2);
        wd_in = 1'b0; cycles(3);
        chk("R7", "131-cycle too_slow", int'(f_slow), 1);
        wd_in = 1'b1; cycles(60);
        train(60, 3);
        chk("R7", "recovery in window", int'(f_win), 1);

        // R2: long low, short high; rising edge must not restart timing
        wd_in = 1'b0; cycles(110); wd_in = 1'b1; cycles(30);
        wd_in = 1'b0; cycles(3);
        chk("R2", "rise ignored slow", int'(f_slow), 1);
        chk("R2", "rise ignored no fast", int'(f_fast), 0);
        cycles(27); wd_in = 1'b1; cycles(30);
        train(60, 3);

        // R4: stuck high then stuck low
        wd_in = 1'b1; cycles(200);
        chk("R4", "stuck high slow", int'(f_slow), 1);
        train(60, 3);
        chk("R7", "good after stuck high", int'(f_win), 1);
        wd_in = 1'b0; cycles(200);
        chk("R4", "stuck low slow", int'(l_slow), 1);
        wd_in = 1'b1; cycles(30);
        train(60, 3);

        // R3: tick on one cycle in three
        tick_div = 3;
        train(200, 3);
        chk("R3", "200-cycle slow ticks in window", int'(f_win), 1);
        train(60, 3);
        chk("R3", "60-cycle slow ticks too_fast", int'(f_fast), 1);
        train(450, 2);
        chk("R3", "450-cycle slow ticks too_slow", int'(f_slow), 1);

        done = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule